// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream. A word of `WIDTH` bits is captured into a chain of stages on one rising clock edge. Later edges move the chain one place toward stage 0, which drives the only output, and a serial input fills the stage at the far end. A chain of these blocks can therefore be cascaded: the output of one feeds the serial input of the next.

A select input decides, at each edge, whether the edge loads or shifts. A synchronous inhibit input makes the edge a no-op and freezes every stage. An active-low clear empties all stages at once without waiting for the clock, and it overrides everything else. The whole block runs in a single clock domain and the inhibit acts as a clock enable.

Top module: `load_shift_reg`

## Requirements
- R1: While `clrN` is low, every stage is 0 and `serOut` is 0 without waiting for a clock edge, and clock edges during that time neither load nor shift.
- R2: At a rising edge with `clrN` high, `clkInhibit` low and `shiftNLoad` low, stage i takes `parData[i]` for every i at once, so `serOut` equals `parData[0]` right after that edge.
- R3: At a rising edge with `clrN` high, `clkInhibit` low and `shiftNLoad` high, stage i takes the old stage i+1, stage `WIDTH-1` takes `serIn`, and `serOut` then shows the old stage 1.
- R4: At a rising edge with `clkInhibit` high and `clrN` high, no stage changes whatever `shiftNLoad`, `serIn` and `parData` hold, so `serOut` keeps its value.
- R5: After a clear with no reload, shifting moves out `WIDTH` zeros before any bit taken from `serIn` reaches `serOut`.
- R6: After a load, `WIDTH-1` further shift edges present `parData[1]` through `parData[WIDTH-1]` on `serOut` in that order, one per edge.
- R7: The first rising edge after `clrN` returns high loads or shifts normally. Inhibit takes priority over load and shift, and clear takes priority over inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge active |
| clrN | input | 1 | Asynchronous clear, active low |
| shiftNLoad | input | 1 | 1 selects shift, 0 selects parallel load |
| clkInhibit | input | 1 | 1 makes clock edges have no effect |
| serIn | input | 1 | Serial fill bit for stage WIDTH-1 |
| parData | input | WIDTH | Parallel word, bit i goes to stage i |
| serOut | output | 1 | Stage 0, the serial output |

## Verification
The functions that collide are the clear and a clock-edge operation. Clear is driven low between edges while a load or shift is selected, so the next rising edge sees both at once. The output is sampled before that edge to confirm the asynchronous clear, and again after it to confirm that the edge did nothing. Inhibit is also held together with every select and data value, and a random run mixes all four controls edge by edge against a bench model of the stages.

// File: rtl/load_shift_pkg.sv
package load_shift_pkg;

  // Per-edge action chosen by the control and consumed by the datapath.
  typedef struct packed {
    logic loadEn;
    logic shiftEn;
  } stepStrobe_t;

endpackage

// File: rtl/load_shift_ctrl.sv
module load_shift_ctrl
  import load_shift_pkg::*;
(
  input  logic        shiftNLoad,
  input  logic        clkInhibit,
  output stepStrobe_t strobe
);

  // Inhibit outranks both actions; the select picks one of the two.
  always_comb begin
    strobe = '0;
    if (!clkInhibit) begin
      strobe.loadEn  = !shiftNLoad;
      strobe.shiftEn = shiftNLoad;
    end
  end

endmodule

// File: rtl/load_shift_dp.sv
module load_shift_dp
  import load_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clrN,
  input  stepStrobe_t      strobe,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parData,
  output logic [WIDTH-1:0] stageQ
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] fillBit;
  logic [WIDTH-1:0] nextQ;

  for (genvar i = 0; i < WIDTH; i++) begin : gStage
    if (i == LAST) begin : gTail
      assign fillBit[i] = serIn;
    end else begin : gBody
      assign fillBit[i] = stageQ[i+1];
    end
    assign nextQ[i] = strobe.loadEn  ? parData[i] :
                      strobe.shiftEn ? fillBit[i] : stageQ[i];
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) stageQ <= '0;
    else       stageQ <= nextQ;
  end

endmodule

// File: rtl/load_shift_reg.sv
module load_shift_reg
  import load_shift_pkg::*;
#(
  parameter int WIDTH = 8   // must be 2 or more
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             shiftNLoad,
  input  logic             clkInhibit,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parData,
  output logic             serOut
);

  stepStrobe_t      strobe;
  logic [WIDTH-1:0] stageQ;

  load_shift_ctrl uCtrl (
    .shiftNLoad (shiftNLoad),
    .clkInhibit (clkInhibit),
    .strobe     (strobe)
  );

  load_shift_dp #(.WIDTH(WIDTH)) uDp (
    .clk     (clk),
    .clrN    (clrN),
    .strobe  (strobe),
    .serIn   (serIn),
    .parData (parData),
    .stageQ  (stageQ)
  );

  assign serOut = stageQ[0];

endmodule

// File: rtl/load_shift_reg_chk.sv
module load_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clrN,
  input logic             shiftNLoad,
  input logic             clkInhibit,
  input logic             serIn,
  input logic [WIDTH-1:0] parData,
  input logic [WIDTH-1:0] stageQ,
  input logic             serOut
);

  // R1: clear holds every stage and the output at zero
  assert_clear_empty_R1: assert property (@(posedge clk)
    !clrN |-> (serOut == 1'b0 && stageQ == '0));

  // R2: a load edge presents parallel bit 0 on the output
  assert_load_visible_R2: assert property (@(posedge clk) disable iff (!clrN)
    (!clkInhibit && !shiftNLoad) |=> (serOut == $past(parData[0]) && stageQ == $past(parData)));

  // R3: a shift edge moves every stage one place and fills from serIn
  assert_shift_step_R3: assert property (@(posedge clk) disable iff (!clrN)
    (!clkInhibit && shiftNLoad) |=>
      (stageQ[WIDTH-1] == $past(serIn) && stageQ[WIDTH-2:0] == $past(stageQ[WIDTH-1:1])));

  // R4: an inhibited edge leaves the output and the stages alone
  assert_inhibit_hold_R4: assert property (@(posedge clk) disable iff (!clrN)
    clkInhibit |=> ($stable(serOut) && $stable(stageQ)));

endmodule

bind load_shift_reg load_shift_reg_chk #(.WIDTH(WIDTH)) uChk (
  .clk        (clk),
  .clrN       (clrN),
  .shiftNLoad (shiftNLoad),
  .clkInhibit (clkInhibit),
  .serIn      (serIn),
  .parData    (parData),
  .stageQ     (stageQ),
  .serOut     (serOut)
);

// File: tb/load_shift_reg_test.sv
module load_shift_reg_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clrN;
  logic         shiftNLoad;
  logic         clkInhibit;
  logic         serIn;
  logic [W-1:0] parData;
  logic         serOut;

  int           vectors = 0;
  int           fails = 0;
  bit           done = 1'b0;
  logic [W-1:0] model;

  always #2 clk = ~clk;   // 4 ns period

  load_shift_reg #(.WIDTH(W)) uut (
    .clk(clk), .clrN(clrN), .shiftNLoad(shiftNLoad), .clkInhibit(clkInhibit),
    .serIn(serIn), .parData(parData), .serOut(serOut)
  );

  task automatic check(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: serOut=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock period: drive after the falling edge, model the rising edge, sample after it.
  task automatic step(input logic cN, input logic sel, input logic inh,
                      input logic ser, input logic [W-1:0] par, input string req);
    @(negedge clk);
    clrN = cN; shiftNLoad = sel; clkInhibit = inh; serIn = ser; parData = par;
    if (!cN) begin
      model = '0;
      #1 check(serOut, 1'b0, "R1 async");
    end
    @(posedge clk);
    if (cN && !inh) model = sel ? {ser, model[W-1:1]} : par;
    #1 check(serOut, model[0], req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    clrN = 1'b0; shiftNLoad = 1'b1; clkInhibit = 1'b0; serIn = 1'b1; parData = '1;
    model = '0;
    #1 check(serOut, 1'b0, "R1 reset");
    step(1'b0, 1'b0, 1'b0, 1'b1, '1, "R1 load during clear");
    step(1'b0, 1'b1, 1'b0, 1'b1, '1, "R1 shift during clear");

    // R7: first edge after release acts normally
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h01, "R7 first edge after clear");

    // R2, R6, R3: every word loaded, then walked out while new bits enter
    for (int v = 0; v < (1 << W); v++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, W'(v), "R2 load");
      for (int k = 1; k < W; k++)
        step(1'b1, 1'b1, 1'b0, ~v[k], W'(~v), "R6 walk");
      for (int k = 0; k < W; k++)
        step(1'b1, 1'b1, 1'b0, 1'b0, W'(v), "R3 fill");
    end

    // R4: inhibit against every select and data value
    for (int v = 0; v < 32; v++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, W'(v * 37 + 1), "R2 load");
      for (int m = 0; m < 4; m++)
        step(1'b1, m[0], 1'b1, m[1], W'(~(v * 37 + 1)), "R4 inhibit");
      step(1'b1, 1'b1, 1'b0, 1'b1, '0, "R3 shift after inhibit");
    end

    // R7: clear beats inhibit, inhibit beats load
    step(1'b1, 1'b0, 1'b0, 1'b0, '1, "R2 load");
    step(1'b0, 1'b0, 1'b1, 1'b1, '1, "R7 clear over inhibit");
    step(1'b1, 1'b0, 1'b1, 1'b1, '1, "R7 inhibit over load");

    // R5: zeros come out after clear without reload
    step(1'b1, 1'b0, 1'b0, 1'b0, '1, "R2 load ones");
    step(1'b0, 1'b1, 1'b0, 1'b1, '1, "R1 clear pulse");
    for (int k = 0; k < W - 1; k++)
      step(1'b1, 1'b1, 1'b0, 1'b1, '1, "R5 zeros out");
    step(1'b1, 1'b1, 1'b0, 1'b1, '1, "R5 first fill bit");

    // Random mix of all controls, clear rare
    for (int n = 0; n < 4000; n++) begin
      automatic int r = $urandom_range(0, 99);
      step((r > 3), $urandom_range(0, 1) != 0, (r % 5) == 0,
           $urandom_range(0, 1) != 0, W'($urandom), "R7 random mix");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule